// File: doc/BRIEF.md
# Read-Sequence Bank Selector

This block sits on a memory bus that several cartridges share and decides which of its sixteen memory banks, if any, answers to that bus. It sees only the read strobe and a four-bit slice of the address (address lines 8 to 11) for each read. A host unlocks a bank by issuing a fixed series of sixteen reads whose address slices spell out a 64-bit key, preceded by one read with the slice at all ones. All other reads, with other slice values, leave the selection alone.

The key is a parameter. The first eleven steps must match it in all four bits. In the final five steps only the upper three bits of the slice are compared, and the lowest bit of each of these steps is collected into a five-bit code. When the code's top bit is 0, the low four bits name the bank to enable. When it is 1, every bank is released. After reset no bank is enabled, so several cartridges can share the bus without conflict until one of them is unlocked.

Top module: `bank_unlock`

## Requirements
- R1: After reset `bankEn` is all zeros and the matcher is idle.
- R2: A cycle with `readStb` low is not a read: the value on `addrNib` in that cycle has no effect on matching or on `bankEn`.
- R3: A read with `addrNib` = 4'b1111 arms the matcher so that the next read is compared with step 1. This applies when the matcher is idle, and also when the read does not match the step the matcher is waiting for.
- R4: Step i (1 to 16) of the key is `PATTERN[64-4*i +: 4]`. For steps 1 to 11 a read matches only if all four bits are equal to that nibble.
- R5: For steps 12 to 16 a read matches if `addrNib[3:1]` equals bits 3:1 of the key nibble. Bit 0 of those five reads forms a code, with the step-12 bit as the MSB (bit 4) and the step-16 bit as the LSB (bit 0).
- R6: On a completed entry, a code with bit 4 = 0 sets `bankEn` to a one-hot value with only bit code[3:0] set. A code with bit 4 = 1 sets `bankEn` to zero.
- R7: `bankEn` changes only on the clock edge that samples the 16th matching read, and it is visible from the next cycle. It never has more than one bit set.
- R8: A read that matches neither the awaited step nor 1111 aborts the entry. The matcher returns to idle and `bankEn` is kept. While the matcher is idle, reads other than 1111 are ignored.
- R9: After an entry completes, the matcher is idle. A further sixteen key reads without a 1111 read before them do not change `bankEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readStb | input | 1 | One-cycle pulse marking a completed bus read |
| addrNib | input | 4 | Address lines 8 to 11 of that read (bit 0 = line 8) |
| bankEn | output | 16 | One-hot bank enable; all zeros means no bank is enabled |

## Verification
The assertions assume that `readStb` marks each bus read in exactly one cycle and that `addrNib` is valid in that cycle. They also assume that the first key nibble is not 1111, which an elaboration-time check enforces. The bench drives each read as a single-cycle pulse between falling clock edges. It varies `addrNib` freely in the cycles where `readStb` is low, so the values seen outside reads cannot affect the result. It uses only the default key, whose first nibble is 5.

// File: rtl/bank_unlock_pkg.sv
package bank_unlock_pkg;

  localparam int NIB_W = 4;

  typedef struct packed {
    logic advance;
    logic resync;
    logic abort;
    logic commit;
  } unlockStrobes_t;

endpackage

// File: rtl/bank_unlock_ctrl.sv
module bank_unlock_ctrl
  import bank_unlock_pkg::*;
#(
  parameter logic [63:0] PATTERN     = 64'h5A3C_96E1_4B72_C4E8,
  parameter int          NUM_STEPS   = 16,
  parameter int          EXACT_STEPS = 11,
  localparam int         STEP_W      = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readStb,
  input  logic [NIB_W-1:0]  addrNib,
  input  logic [STEP_W-1:0] stepIdx,
  output unlockStrobes_t    strb,
  output logic              armed
);

  logic [NIB_W-1:0] expNib;
  logic             stepMatch;
  logic             isResyncNib;
  logic             lastStep;

  always_comb begin
    expNib = '0;
    for (int i = 0; i < NUM_STEPS; i++) begin
      if (stepIdx == STEP_W'(i)) expNib = PATTERN[(NUM_STEPS-1-i)*NIB_W +: NIB_W];
    end
  end

  assign isResyncNib = (addrNib == '1);
  assign lastStep    = (stepIdx == STEP_W'(NUM_STEPS-1));

  always_comb begin
    if (stepIdx < STEP_W'(EXACT_STEPS)) stepMatch = (addrNib == expNib);
    else                                stepMatch = (addrNib[NIB_W-1:1] == expNib[NIB_W-1:1]);
  end

  always_comb begin
    strb = '0;
    if (readStb) begin
      if (armed && stepMatch) begin
        strb.advance = 1'b1;
        strb.commit  = lastStep;
      end else if (isResyncNib) begin
        strb.resync = 1'b1;
      end else if (armed) begin
        strb.abort = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         armed <= 1'b0;
    else if (strb.resync)              armed <= 1'b1;
    else if (strb.commit || strb.abort) armed <= 1'b0;
  end

  initial begin
    p_first_step_not_resync_r3: assert (PATTERN[NUM_STEPS*NIB_W-1 -: NIB_W] != '1);
  end

  p_idle_ignores_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && readStb && !isResyncNib) |=> !armed);

  p_resync_arms_r3: assert property (@(posedge clk) disable iff (!rstN)
    (readStb && isResyncNib && !(armed && stepMatch)) |=> armed);

  p_no_strobe_no_change_r2: assert property (@(posedge clk) disable iff (!rstN)
    !readStb |=> $stable(armed));

endmodule

// File: rtl/bank_unlock_dp.sv
module bank_unlock_dp
  import bank_unlock_pkg::*;
#(
  parameter int  NUM_STEPS   = 16,
  parameter int  EXACT_STEPS = 11,
  localparam int STEP_W      = $clog2(NUM_STEPS),
  localparam int CODE_W      = NUM_STEPS - EXACT_STEPS,
  localparam int BANK_W      = CODE_W - 1,
  localparam int NUM_BANKS   = 2 ** BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NIB_W-1:0]     addrNib,
  input  unlockStrobes_t       strb,
  output logic [STEP_W-1:0]    stepIdx,
  output logic [NUM_BANKS-1:0] bankEn
);

  logic [CODE_W-1:0]    codeAcc;
  logic [CODE_W-1:0]    finalCode;
  logic [NUM_BANKS-1:0] decoded;
  logic                 inCodeSteps;

  assign inCodeSteps = (stepIdx >= STEP_W'(EXACT_STEPS));
  assign finalCode   = {codeAcc[CODE_W-2:0], addrNib[0]};

  always_ff @(posedge clk) begin
    if (!rstN)                            stepIdx <= '0;
    else if (strb.resync || strb.abort)   stepIdx <= '0;
    else if (strb.advance)                stepIdx <= strb.commit ? '0 : stepIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                 codeAcc <= '0;
    else if (strb.resync)                      codeAcc <= '0;
    else if (strb.advance && inCodeSteps)      codeAcc <= finalCode;
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
      assign decoded[g] = !finalCode[CODE_W-1] && (finalCode[BANK_W-1:0] == BANK_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            bankEn <= '0;
    else if (strb.commit) bankEn <= decoded;
  end

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rstN) $onehot0(bankEn));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(bankEn));

  p_commit_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (stepIdx == STEP_W'(NUM_STEPS-1)));

  p_step_adv_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.commit) |=> (stepIdx == $past(stepIdx) + 1'b1));

  p_after_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (stepIdx == '0));

endmodule

// File: rtl/bank_unlock.sv
module bank_unlock
  import bank_unlock_pkg::*;
#(
  parameter logic [63:0] PATTERN     = 64'h5A3C_96E1_4B72_C4E8,
  parameter int          NUM_STEPS   = 16,
  parameter int          EXACT_STEPS = 11,
  localparam int         STEP_W      = $clog2(NUM_STEPS),
  localparam int         NUM_BANKS   = 2 ** (NUM_STEPS - EXACT_STEPS - 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 readStb,
  input  logic [3:0]           addrNib,
  output logic [NUM_BANKS-1:0] bankEn
);

  unlockStrobes_t    strb;
  logic [STEP_W-1:0] stepIdx;
  logic              armed;

  bank_unlock_ctrl #(
    .PATTERN(PATTERN), .NUM_STEPS(NUM_STEPS), .EXACT_STEPS(EXACT_STEPS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .readStb(readStb), .addrNib(addrNib),
    .stepIdx(stepIdx), .strb(strb), .armed(armed)
  );

  bank_unlock_dp #(
    .NUM_STEPS(NUM_STEPS), .EXACT_STEPS(EXACT_STEPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addrNib(addrNib), .strb(strb),
    .stepIdx(stepIdx), .bankEn(bankEn)
  );

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rstN)
    !readStb |=> $stable(bankEn));

endmodule

// File: tb/sim_bank_unlock.sv
module sim_bank_unlock;

  localparam logic [63:0] PAT = 64'h5A3C_96E1_4B72_C4E8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        readStb = 1'b0;
  logic [3:0]  addrNib = 4'h0;
  logic [15:0] bankEn;
  logic [15:0] expEn = '0;
  int          nChecks = 0;
  int          nFails = 0;

  always #5 clk = ~clk;

  bank_unlock u0 (.clk(clk), .rstN(rstN), .readStb(readStb), .addrNib(addrNib), .bankEn(bankEn));

  function automatic logic [3:0] patNib(input int i);
    return PAT[64-4*i +: 4];
  endfunction

  function automatic logic [3:0] keyNib(input int i, input logic [4:0] code);
    if (i <= 11) return patNib(i);
    return {patNib(i)[3:1], code[16-i]};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    nChecks++;
    if (bankEn !== exp) begin
      nFails++;
      $display("FAIL %s: bankEn=%h expected %h", req, bankEn, exp);
    end
  endtask

  task automatic rd(input logic [3:0] n);
    @(negedge clk); readStb = 1'b1; addrNib = n;
    @(negedge clk); readStb = 1'b0; addrNib = ~n;
  endtask

  task automatic keySteps(input int first, input int last, input logic [4:0] code);
    for (int i = first; i <= last; i++) rd(keyNib(i, code));
  endtask

  task automatic fullEntry(input logic [4:0] code, input string req);
    rd(4'hF);
    keySteps(1, 15, code);
    check("R7", expEn);
    rd(keyNib(16, code));
    expEn = code[4] ? 16'h0 : (16'h1 << code[3:0]);
    check(req, expEn);
  endtask

  task automatic t_reset();
    check("R1", 16'h0);
  endtask

  task automatic t_select();
    fullEntry(5'b0_0101, "R6");
    fullEntry(5'b0_0000, "R5");
    fullEntry(5'b0_1111, "R6");
    fullEntry(5'b1_0011, "R6");
    fullEntry(5'b0_1001, "R5");
  endtask

  task automatic t_abort_exact();
    rd(4'hF); keySteps(1, 4, 5'b0_0010);
    rd(patNib(5) ^ 4'h1);
    keySteps(6, 16, 5'b0_0010);
    check("R4", expEn);
    rd(4'hF); keySteps(1, 5, 5'b0_0010);
    rd(4'h0);
    keySteps(7, 16, 5'b0_1010);
    check("R8", expEn);
  endtask

  task automatic t_abort_upper();
    rd(4'hF); keySteps(1, 12, 5'b0_0011);
    rd(keyNib(13, 5'b0_0011) ^ 4'h8);
    keySteps(14, 16, 5'b0_0011);
    check("R5", expEn);
  endtask

  task automatic t_no_resync();
    fullEntry(5'b0_0111, "R6");
    keySteps(1, 16, 5'b0_0001);
    check("R9", expEn);
  endtask

  task automatic t_resync_mid();
    rd(4'hF); keySteps(1, 4, 5'b0_1100);
    fullEntry(5'b0_1100, "R3");
    rd(4'hF);
    fullEntry(5'b0_0010, "R3");
  endtask

  task automatic t_strobe_low();
    rd(4'hF); keySteps(1, 6, 5'b0_1011);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); addrNib = 4'(k);
    end
    keySteps(7, 15, 5'b0_1011);
    @(negedge clk); addrNib = 4'h3;
    @(negedge clk);
    check("R2", expEn);
    rd(keyNib(16, 5'b0_1011));
    expEn = 16'h1 << 11;
    check("R2", expEn);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_abort_exact();
    t_abort_upper();
    t_no_resync();
    t_resync_mid();
    t_strobe_low();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule